// File: doc/BRIEF.md
# Integer ADD Instruction Byte Decoder

This block takes a stream of instruction bytes, one per clock, over a valid/ready handshake. It recognises every encoding of the integer ADD instruction in the one-byte opcode space. For each instruction it collects the opcode, then the ModRM byte when the form has one, then the immediate bytes. When the last byte has been taken, it presents one decoded record for a single cycle. The record gives the operand width, which operand is written, whether the implicit accumulator is used, the ModRM fields and the immediate value. A short immediate is already sign-extended when the encoding asks for that.

A mode input selects 16-bit or 32-bit operands for the forms that are not byte forms. Any byte that does not start an ADD encoding is reported as an illegal record. So is a group-1 opcode whose ModRM reg field selects some other operation. After either case the decoder waits for a fresh opcode. Prefixes, SIB bytes, displacements and memory accesses are outside this block.

Top module: `add_byte_decoder`

## Requirements
- R1: While rst_n is low at a rising clock edge, all partial decode state and any outstanding immediate count are dropped. After reset, in_ready is 1, out_valid is 0, and the next accepted byte is treated as an opcode.
- R2: A byte is taken only at an edge where in_valid and in_ready are both 1. out_valid is 1 for exactly the one cycle after the edge that takes an instruction's last byte. in_ready is 0 in that cycle and 1 in every other cycle.
- R3: Opcodes 0x00 to 0x03 take one ModRM byte and no immediate. Opcode bit 1 gives out_reg_dst: 1 means the register is written, 0 means the r/m operand is written. Opcode bit 0 gives the width: 0 is a byte, 1 is the mode width. out_mod, out_reg and out_rm are ModRM bits [7:6], [5:3] and [2:0]. out_acc is 0 and out_imm is 0.
- R4: Opcodes 0x04 and 0x05 take no ModRM byte. out_acc=1, out_reg_dst=1, and out_mod, out_reg and out_rm are 0. Opcode 0x04 takes one immediate byte with byte width. Opcode 0x05 takes 2 or 4 immediate bytes, following the mode width.
- R5: Opcodes 0x80 and 0x81 with ModRM reg field 0 give out_reg_dst=0 and out_acc=0. Opcode 0x80 is byte width with one immediate byte. Opcode 0x81 is mode width, with an immediate of 2 or 4 bytes to match.
- R6: Opcode 0x83 with ModRM reg field 0 is mode width with one immediate byte. That byte is sign-extended to 16 bits (bits 31:16 are 0) or to 32 bits.
- R7: Immediate bytes are assembled least significant byte first. out_imm bits above the immediate's width (after any extension) are 0.
- R8: size32 is sampled only at the edge that takes the opcode. The mode width is 32 when size32=1 and 16 when size32=0. out_size encodes width as 0 for 8 bits, 1 for 16 bits and 2 for 32 bits.
- R9: When opcode 0x80, 0x81 or 0x83 is followed by a ModRM byte whose reg field is not 0, an illegal record follows that ModRM byte. No immediate byte is consumed, and the next byte is an opcode.
- R10: Any opcode other than 0x00 to 0x05, 0x80, 0x81 and 0x83 produces an illegal record after that single byte. In an illegal record, out_illegal=1 and every other record field is 0.
- R11: Cycles with in_valid=0 do not change decode progress, whatever in_byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| size32 | input | 1 | Mode width select: 1 for 32-bit, 0 for 16-bit |
| in_valid | input | 1 | in_byte holds a byte |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Record valid, one cycle |
| out_illegal | output | 1 | Record is not an ADD encoding |
| out_size | output | 2 | Operand width: 0 for 8, 1 for 16, 2 for 32 |
| out_reg_dst | output | 1 | 1 when the register operand is the destination |
| out_acc | output | 1 | Accumulator form |
| out_mod | output | 2 | ModRM mod field |
| out_reg | output | 3 | ModRM reg field |
| out_rm | output | 3 | ModRM r/m field |
| out_imm | output | 32 | Immediate value, extended as required |

## Verification
The assertions assume that reset is applied at the start and that the decoder takes bytes only through the handshake. Records are judged only while out_valid is high, since the outputs are undefined otherwise. The stimulus applies reset before any byte and never expects a byte to be taken while in_ready is low. Between bytes, it drops in_valid for random stretches and puts random garbage on in_byte. size32 is also changed freely after the opcode, to show that only the value at the opcode edge counts. The random mix covers all nine ADD opcodes, illegal bytes, and group opcodes with both zero and non-zero reg fields. Directed cases cover a reset in the middle of an instruction and the sign extension of 0x80 and 0x7F.

// File: rtl/add_dec_pkg.sv
// Shared types for the ADD byte decoder.
// Assumes operand widths are 8, 16 or 32 bits only.
package add_dec_pkg;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2
    } opsize_e;

    typedef enum logic [1:0] {
        ST_OPC,
        ST_MODRM,
        ST_IMM,
        ST_OUT
    } dec_state_e;

    typedef struct packed {
        logic       known;      // opcode belongs to the ADD family
        logic       has_modrm;  // a ModRM byte follows
        logic       group;      // ADD only if ModRM reg field is zero
        opsize_e    size;       // operand width
        logic       reg_dst;    // register operand is written
        logic       acc;        // implicit accumulator form
        logic [2:0] imm_bytes;  // immediate bytes that follow
        logic       sext;       // immediate byte is sign-extended
    } opc_info_t;

endpackage

// File: rtl/add_opc_classify.sv
// Combinational opcode classifier for the ADD family.
// Assumes wide_mode already reflects the operand-size mode for this opcode.
module add_opc_classify
    import add_dec_pkg::*;
(
    input  logic [7:0] opc,
    input  logic       wide_mode,
    output opc_info_t  info
);

    opsize_e    wsize;
    logic [2:0] wbytes;

    // Purpose: pick the mode width and its immediate length.
    always_comb begin
        wsize  = wide_mode ? SZ_32 : SZ_16;
        wbytes = wide_mode ? 3'd4 : 3'd2;
    end

    // Purpose: map each opcode to its decode attributes.
    always_comb begin
        info = '0;
        case (opc)
            8'h00, 8'h01, 8'h02, 8'h03: begin
                info.known     = 1'b1;
                info.has_modrm = 1'b1;
                info.size      = opc[0] ? wsize : SZ_8;
                info.reg_dst   = opc[1];
            end
            8'h04: begin
                info.known     = 1'b1;
                info.size      = SZ_8;
                info.reg_dst   = 1'b1;
                info.acc       = 1'b1;
                info.imm_bytes = 3'd1;
            end
            8'h05: begin
                info.known     = 1'b1;
                info.size      = wsize;
                info.reg_dst   = 1'b1;
                info.acc       = 1'b1;
                info.imm_bytes = wbytes;
            end
            8'h80: begin
                info.known     = 1'b1;
                info.has_modrm = 1'b1;
                info.group     = 1'b1;
                info.size      = SZ_8;
                info.imm_bytes = 3'd1;
            end
            8'h81: begin
                info.known     = 1'b1;
                info.has_modrm = 1'b1;
                info.group     = 1'b1;
                info.size      = wsize;
                info.imm_bytes = wbytes;
            end
            8'h83: begin
                info.known     = 1'b1;
                info.has_modrm = 1'b1;
                info.group     = 1'b1;
                info.size      = wsize;
                info.imm_bytes = 3'd1;
                info.sext      = 1'b1;
            end
            default: info = '0;
        endcase
    end

endmodule

// File: rtl/add_imm_collect.sv
// Little-endian immediate assembler: one byte lane written per strobe.
// Assumes idx stays below LANES while wr is high.
module add_imm_collect #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [IDX_W-1:0]        idx,
    input  logic [LANE_W-1:0]       din,
    output logic [LANES*LANE_W-1:0] value
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        // Purpose: clear the lane on a new instruction, or load it when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lane_q <= '0;
            end else if (wr && idx == IDX_W'(g)) begin
                lane_q <= din;
            end
        end

        assign value[g*LANE_W +: LANE_W] = lane_q;
    end

endmodule

// File: rtl/add_imm_extend.sv
// Sign extension of a single immediate byte to the operand width.
// Assumes only bits [7:0] of raw are meaningful when sext is set.
module add_imm_extend
    import add_dec_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic [IMM_W-1:0] raw,
    input  opsize_e          size,
    input  logic             sext,
    output logic [IMM_W-1:0] value
);

    logic [7:0] lo;
    assign lo = raw[7:0];

    // Purpose: widen the low byte by its sign bit up to the operand width.
    always_comb begin
        value = raw;
        if (sext) begin
            case (size)
                SZ_32:   value = {{(IMM_W-8){lo[7]}}, lo};
                SZ_16:   value = {{(IMM_W-16){1'b0}}, {8{lo[7]}}, lo};
                default: value = raw;
            endcase
        end
    end

endmodule

// File: rtl/add_byte_decoder.sv
// Byte-serial decoder for the ADD instruction family.
// Takes opcode, optional ModRM, then immediate bytes. Emits one record
// per instruction for a single cycle, during which no byte is taken.
// Assumes the caller has stripped prefixes and supplies the mode width on size32.
module add_byte_decoder
    import add_dec_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             size32,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [1:0]       out_size,
    output logic             out_reg_dst,
    output logic             out_acc,
    output logic [1:0]       out_mod,
    output logic [2:0]       out_reg,
    output logic [2:0]       out_rm,
    output logic [IMM_W-1:0] out_imm
);

    localparam int LANES = IMM_W / 8;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CNT_W = $clog2(LANES + 1);

    dec_state_e       state_q;
    opc_info_t        cur_info;
    opsize_e          size_q;
    logic             dst_q, acc_q, grp_q, sext_q, illegal_q;
    logic [7:0]       modrm_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept;
    logic [IMM_W-1:0] imm_raw, imm_ext;

    assign accept = in_valid && in_ready;

    add_opc_classify u_classify (
        .opc       (in_byte),
        .wide_mode (size32),
        .info      (cur_info)
    );

    // Purpose: walk opcode, ModRM and immediate phases, then hold the record one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OPC;
            size_q    <= SZ_8;
            dst_q     <= 1'b0;
            acc_q     <= 1'b0;
            grp_q     <= 1'b0;
            sext_q    <= 1'b0;
            illegal_q <= 1'b0;
            modrm_q   <= '0;
            cnt_q     <= '0;
            idx_q     <= '0;
        end else begin
            case (state_q)
                ST_OPC: if (accept) begin
                    size_q    <= cur_info.size;
                    dst_q     <= cur_info.reg_dst;
                    acc_q     <= cur_info.acc;
                    grp_q     <= cur_info.group;
                    sext_q    <= cur_info.sext;
                    illegal_q <= !cur_info.known;
                    modrm_q   <= '0;
                    idx_q     <= '0;
                    cnt_q     <= CNT_W'(cur_info.imm_bytes);
                    if (!cur_info.known)        state_q <= ST_OUT;
                    else if (cur_info.has_modrm) state_q <= ST_MODRM;
                    else                         state_q <= ST_IMM;
                end
                ST_MODRM: if (accept) begin
                    modrm_q <= in_byte;
                    if (grp_q && in_byte[5:3] != 3'd0) begin
                        illegal_q <= 1'b1;
                        state_q   <= ST_OUT;
                    end else if (cnt_q != '0) begin
                        state_q <= ST_IMM;
                    end else begin
                        state_q <= ST_OUT;
                    end
                end
                ST_IMM: if (accept) begin
                    idx_q <= idx_q + 1'b1;
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) state_q <= ST_OUT;
                end
                default: state_q <= ST_OPC;
            endcase
        end
    end

    add_imm_collect #(
        .LANE_W (8),
        .LANES  (LANES)
    ) u_collect (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept && state_q == ST_OPC),
        .wr    (accept && state_q == ST_IMM),
        .idx   (idx_q),
        .din   (in_byte),
        .value (imm_raw)
    );

    add_imm_extend #(
        .IMM_W (IMM_W)
    ) u_extend (
        .raw   (imm_raw),
        .size  (size_q),
        .sext  (sext_q),
        .value (imm_ext)
    );

    // Purpose: drive the handshake and the record, zeroing fields of an illegal record.
    always_comb begin
        in_ready    = (state_q != ST_OUT);
        out_valid   = (state_q == ST_OUT);
        out_illegal = illegal_q;
        out_size    = illegal_q ? 2'd0 : size_q;
        out_reg_dst = !illegal_q && dst_q;
        out_acc     = !illegal_q && acc_q;
        out_mod     = illegal_q ? 2'd0 : modrm_q[7:6];
        out_reg     = illegal_q ? 3'd0 : modrm_q[5:3];
        out_rm      = illegal_q ? 3'd0 : modrm_q[2:0];
        out_imm     = illegal_q ? '0 : imm_ext;
    end

endmodule

// File: rtl/add_byte_decoder_chk.sv
// Property checker for add_byte_decoder, attached by bind.
// Assumes reset is asserted before the first byte is offered.
module add_byte_decoder_chk #(
    parameter int IMM_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_illegal,
    input logic [1:0]       out_size,
    input logic             out_reg_dst,
    input logic             out_acc,
    input logic [1:0]       out_mod,
    input logic [2:0]       out_reg,
    input logic [2:0]       out_rm,
    input logic [IMM_W-1:0] out_imm
);

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r2_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready));

    a_r4_acc_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_acc) |-> (out_reg_dst && out_mod == 2'd0 && out_reg == 3'd0 && out_rm == 3'd0));

    a_r7_imm_fits8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_size == 2'd0) |-> (out_imm[IMM_W-1:8] == '0));

    a_r7_imm_fits16: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_size == 2'd1) |-> (out_imm[IMM_W-1:16] == '0));

    a_r8_size_code: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_size != 2'd3));

    a_r10_illegal_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_size == 2'd0 && !out_acc && !out_reg_dst &&
                                        out_mod == 2'd0 && out_reg == 3'd0 &&
                                        out_rm == 3'd0 && out_imm == '0));

endmodule

bind add_byte_decoder add_byte_decoder_chk #(.IMM_W(IMM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_size    (out_size),
    .out_reg_dst (out_reg_dst),
    .out_acc     (out_acc),
    .out_mod     (out_mod),
    .out_reg     (out_reg),
    .out_rm      (out_rm),
    .out_imm     (out_imm)
);

// File: tb/add_byte_decoder_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random instructions.
module add_byte_decoder_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        ill;
        logic [1:0]  size;
        logic        dst;
        logic        acc;
        logic [1:0]  mod;
        logic [2:0]  rg;
        logic [2:0]  rm;
        logic [31:0] imm;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        size32 = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, out_valid, out_illegal, out_reg_dst, out_acc;
    logic [1:0]  out_size, out_mod;
    logic [2:0]  out_reg, out_rm;
    logic [31:0] out_imm;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    add_byte_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .size32(size32), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_illegal(out_illegal),
        .out_size(out_size), .out_reg_dst(out_reg_dst), .out_acc(out_acc),
        .out_mod(out_mod), .out_reg(out_reg), .out_rm(out_rm), .out_imm(out_imm)
    );

    // Reference model: expected record and byte count from the requirements.
    function automatic rec_t model(input logic [7:0] op, input logic [7:0] mr,
                                   input logic [31:0] immv, input logic w,
                                   output int n, output string tag);
        rec_t r = '0;
        int   immn = 0;
        bit   known = 1, hasmr = 0, grp = 0, sx = 0;
        logic [1:0]  wsz = w ? 2'd2 : 2'd1;
        int          wn  = w ? 4 : 2;
        logic [31:0] v;
        n = 1;
        case (op)
            8'h00: begin hasmr = 1; r.size = 2'd0; tag = "R3"; end
            8'h01: begin hasmr = 1; r.size = wsz;  tag = "R3"; end
            8'h02: begin hasmr = 1; r.size = 2'd0; r.dst = 1; tag = "R3"; end
            8'h03: begin hasmr = 1; r.size = wsz;  r.dst = 1; tag = "R3"; end
            8'h04: begin r.size = 2'd0; r.dst = 1; r.acc = 1; immn = 1;  tag = "R4"; end
            8'h05: begin r.size = wsz;  r.dst = 1; r.acc = 1; immn = wn; tag = "R4"; end
            8'h80: begin hasmr = 1; grp = 1; r.size = 2'd0; immn = 1;  tag = "R5"; end
            8'h81: begin hasmr = 1; grp = 1; r.size = wsz;  immn = wn; tag = "R5"; end
            8'h83: begin hasmr = 1; grp = 1; r.size = wsz;  immn = 1; sx = 1; tag = "R6"; end
            default: begin known = 0; tag = "R10"; end
        endcase
        if (!known) begin
            r = '0; r.ill = 1'b1; return r;
        end
        if (hasmr) begin
            n = 2;
            if (grp && mr[5:3] != 3'd0) begin
                r = '0; r.ill = 1'b1; tag = "R9"; return r;
            end
            r.mod = mr[7:6]; r.rg = mr[5:3]; r.rm = mr[2:0];
        end
        n += immn;
        case (immn)
            4:       v = immv;
            2:       v = {16'h0, immv[15:0]};
            1:       v = {24'h0, immv[7:0]};
            default: v = 32'h0;
        endcase
        if (sx) v = w ? {{24{immv[7]}}, immv[7:0]} : {16'h0, {8{immv[7]}}, immv[7:0]};
        r.imm = v;
        return r;
    endfunction

    function automatic rec_t actual();
        rec_t a;
        a.ill = out_illegal; a.size = out_size; a.dst = out_reg_dst; a.acc = out_acc;
        a.mod = out_mod; a.rg = out_reg; a.rm = out_rm; a.imm = out_imm;
        return a;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Send one instruction, optionally with idle gaps and garbage, then check the record.
    task automatic run_instr(input logic [7:0] op, input logic [7:0] mr,
                             input logic [31:0] immv, input logic w, input bit stall);
        int          n;
        string       tag;
        rec_t        exp = model(op, mr, immv, w, n, tag);
        logic [7:0]  bs [6];
        int          k = 1;
        rec_t        act;
        bs[0] = op;
        if (n >= 2 && op != 8'h04 && op != 8'h05) begin bs[1] = mr; k = 2; end
        for (int i = 0; k + i < 6; i++) bs[k + i] = immv[8*(i%4) +: 8];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (stall && $urandom_range(0, 2) == 0) begin
                in_valid = 1'b0;
                repeat ($urandom_range(1, 3)) begin
                    in_byte = 8'($urandom);
                    @(negedge clk);
                end
            end
            if (i == 0) size32 = w;
            in_valid = 1'b1;
            in_byte  = bs[i];
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'($urandom);
            size32   = 1'($urandom);   // R8: only the opcode-edge value counts
            if (i < n - 1)
                check(!out_valid && in_ready, "R2 R11 mid-instruction", {62'h0, out_valid, in_ready}, 64'h1);
        end
        act = actual();
        check(out_valid && !in_ready, "R2 record strobe", {62'h0, out_valid, in_ready}, 64'h2);
        check(act == exp, tag, 64'(act), 64'(exp));
        @(negedge clk);
        check(!out_valid && in_ready, "R2 single cycle", {62'h0, out_valid, in_ready}, 64'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [9];
        ops = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h80, 8'h81, 8'h83};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 reset state", {62'h0, out_valid, in_ready}, 64'h1);

        // Directed corner cases
        run_instr(8'h83, 8'hC1, 32'h80, 1'b1, 0);         // R6 -> FFFFFF80
        run_instr(8'h83, 8'hC1, 32'h80, 1'b0, 0);         // R6 -> 0000FF80
        run_instr(8'h83, 8'h05, 32'h7F, 1'b1, 0);         // R6 positive
        run_instr(8'h81, 8'hC3, 32'h1234, 1'b0, 0);       // R5 16-bit
        run_instr(8'h05, 8'h00, 32'h12345678, 1'b1, 0);   // R4 R7 little-endian
        run_instr(8'h04, 8'h00, 32'h000000AB, 1'b0, 1);   // R4 R11
        run_instr(8'h80, 8'h08, 32'h0, 1'b0, 0);          // R9 reg=1
        run_instr(8'h00, 8'hD8, 32'h0, 1'b0, 0);          // R3 after R9: next byte is opcode
        run_instr(8'h0F, 8'h00, 32'h0, 1'b0, 0);          // R10
        run_instr(8'h82, 8'h00, 32'h0, 1'b1, 0);          // R10
        run_instr(8'h03, 8'h7A, 32'h0, 1'b1, 1);          // R3 register destination

        // R1: reset in the middle of an instruction
        @(negedge clk); size32 = 1'b1; in_valid = 1'b1; in_byte = 8'h81;
        @(negedge clk); in_byte = 8'hC0;
        @(negedge clk); in_byte = 8'h11;
        @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(!out_valid && in_ready, "R1 mid-instruction reset", {62'h0, out_valid, in_ready}, 64'h1);
        run_instr(8'h04, 8'h00, 32'h5A, 1'b1, 0);         // R1 next byte is an opcode

        // Constrained random mix
        for (int t = 0; t < 400; t++) begin
            int         sel = $urandom_range(0, 11);
            logic [7:0] op  = (sel < 9) ? ops[sel] : 8'($urandom);
            logic [7:0] mr  = 8'($urandom);
            if ((op == 8'h80 || op == 8'h81 || op == 8'h83) && $urandom_range(0, 1) == 1)
                mr[5:3] = 3'd0;
            run_instr(op, mr, $urandom, 1'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule